// File: doc/BRIEF.md
# HDLC Bit-Synchronous Receive Deframer

This block turns a serial line, qualified by a bit enable, into packet bytes. In framed mode it hunts for the flag pattern and drops the zeros that the sender inserted after runs of five ones. A run of seven ones is treated as an abort. It checks a frame check sequence of the selected width and keeps those check bytes off its output. When enabled, it also flags frames whose bit count is not a whole number of octets. Every delivered byte is a one-cycle pulse on a byte-wide output. The first byte of a frame carries a start marker. The last byte carries an end marker together with its abort, check and length status.

In transparent mode every group of eight received bits is delivered as a byte. In this mode the block does no flag hunting, zero removal, abort detection, length checking or FCS checking, and it never marks a start or an end. In both modes, line inversion and bit order apply to every received bit. Inversion is applied before any flag detection. The configuration inputs are expected to change only while reset is held.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: In framed mode, the data bits between an opening flag (01111110) and the next flag form a frame. Its delivered bytes come out in order, the first with out_sop=1 and the last with out_eop=1, and a single-byte frame carries both markers.
- R2: In framed mode, a 0 that follows five consecutive 1s is discarded and never reaches a delivered byte.
- R3: In framed mode, a seventh consecutive 1 aborts the open frame. The last byte already completed before the abort is delivered with out_eop=1 and out_abort=1, and both check flags are 0. The block then ignores the line until the next flag.
- R4: cfg_crc_sel encoding: 00 and 11 mean no check. 01 means a 16-bit check with reflected polynomial 0x8408, all-ones start and good residue 0xF0B8. 10 means a 32-bit check with reflected polynomial 0xEDB88320, all-ones start and good residue 0xDEBB20E3. The check runs over the destuffed bits in line order. The 2 or 4 check bytes are never delivered, and out_crc_err=1 on the end byte when the residue differs.
- R5: With cfg_len_chk=1, a frame whose data bit count is not a multiple of eight ends with out_len_err=1. With cfg_len_chk=0, out_len_err stays 0.
- R6: With cfg_transparent=1, every eight received bits, counted from reset, are delivered as one byte. Flags, ones runs and zeros pass through untouched, and out_sop and out_eop stay 0.
- R7: With cfg_msb_first=0 the first received bit of an octet becomes data bit 0. With cfg_msb_first=1 it becomes bit 7.
- R8: With cfg_invert=1 each received bit is complemented before any other processing.
- R9: Back-to-back flags, flags sharing a zero, and idle ones with no open frame deliver nothing. A frame with fewer completed bytes than check bytes plus one delivers nothing.
- R10: After reset all outputs are 0, and framed mode delivers nothing until the first flag has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial line bit |
| cfg_transparent | input | 1 | 1 selects transparent mode |
| cfg_crc_sel | input | 2 | Check select, encoding per R4 |
| cfg_len_chk | input | 1 | Enables the octet-length check |
| cfg_msb_first | input | 1 | Bit order per R7 |
| cfg_invert | input | 1 | Complements the line per R8 |
| out_valid | output | 1 | A byte is delivered this cycle |
| out_data | output | BYTE_W | Delivered byte |
| out_sop | output | 1 | First byte of a frame |
| out_eop | output | 1 | Last byte of a frame |
| out_abort | output | 1 | Frame ended by abort (with out_eop) |
| out_crc_err | output | 1 | Check residue mismatch (with out_eop) |
| out_len_err | output | 1 | Non-octet frame length (with out_eop) |

## Verification
The hardest situation to reach is a frame end in which stuffed zeros, check bytes and the flag's own leading bits all meet in the seven-bit delay and the byte hold line at the same moment. The scoreboard driver stuffs its own bits and computes both check sequences in line order. It sends payloads dense in 0xFF, 0x7E and 0x3F, so stuffing often falls inside the check bytes and right before the closing flag. Aborts are made with a last byte ending in zero, so that the partial byte caught in the delay is provably discarded. Idle ones, shared-zero flags and an empty checked frame test that nothing leaks out.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   typedef enum logic [1:0] {
      FCS_NONE = 2'b00,
      FCS_16   = 2'b01,
      FCS_32   = 2'b10,
      FCS_OFF  = 2'b11
   } fcs_sel_e;

   localparam logic [15:0] CRC16_POLY    = 16'h8408;
   localparam logic [15:0] CRC16_RESIDUE = 16'hF0B8;
   localparam logic [31:0] CRC32_POLY    = 32'hEDB88320;
   localparam logic [31:0] CRC32_RESIDUE = 32'hDEBB20E3;

   // number of check bytes trailing a frame for a given select value
   function automatic int fcs_bytes(input logic [1:0] sel);
      case (fcs_sel_e'(sel))
         FCS_16:  return 2;
         FCS_32:  return 4;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/hdlc_rx_flagger.sv
// Flag hunt, stuffed-zero removal and abort detection.
// Accepted bits pass a delay of RUN_LEN+1 stages so the bits of a flag
// are dropped before they can reach the octet assembler.
module hdlc_rx_flagger #(
   parameter int RUN_LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_v,
   input  logic in_b,
   output logic dat_v,
   output logic dat_b,
   output logic flag_p,
   output logic abort_p
);
   localparam int DLY = RUN_LEN + 1;
   localparam int OW  = $clog2(RUN_LEN + 2);
   localparam int DW  = $clog2(DLY + 1);

   if (RUN_LEN < 2) begin : g_bad_run
      $error("hdlc_rx_flagger: RUN_LEN must be at least 2");
   end

   logic [OW-1:0]  ones;
   logic [DLY-1:0] dly;
   logic [DW-1:0]  dcnt;
   logic           sync;

   logic stuffed, flag_c, abort_c, accept;

   always_comb begin
      stuffed = in_v && !in_b && (ones == OW'(RUN_LEN - 1));
      flag_c  = in_v && !in_b && (ones == OW'(RUN_LEN));
      abort_c = in_v &&  in_b && (ones == OW'(RUN_LEN));
      accept  = in_v && !stuffed && !flag_c && !(in_b && ones >= OW'(RUN_LEN));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones    <= '0;
         dly     <= '0;
         dcnt    <= '0;
         sync    <= 1'b0;
         dat_v   <= 1'b0;
         dat_b   <= 1'b0;
         flag_p  <= 1'b0;
         abort_p <= 1'b0;
      end else begin
         dat_v   <= 1'b0;
         flag_p  <= 1'b0;
         abort_p <= 1'b0;
         if (in_v) begin
            if (in_b) begin
               if (ones != OW'(RUN_LEN + 1)) ones <= ones + 1'b1;
            end else begin
               ones <= '0;
            end
         end
         if (flag_c) begin
            sync   <= 1'b1;
            dcnt   <= '0;
            flag_p <= 1'b1;
         end else if (abort_c) begin
            sync    <= 1'b0;
            dcnt    <= '0;
            abort_p <= sync;
         end else if (accept) begin
            dly <= {dly[DLY-2:0], in_b};
            if (dcnt == DW'(DLY)) begin
               dat_v <= sync;
               dat_b <= dly[DLY-1];
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end
      end
   end

   AST_FLAG_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(flag_p && abort_p)); // R3
   AST_DATA_NOT_AT_EVENT: assert property (@(posedge clk) disable iff (!rst_n) !(dat_v && (flag_p || abort_p))); // R1
   AST_NO_DATA_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n) abort_p |=> !dat_v); // R3

endmodule

// File: rtl/hdlc_rx_crc.sv
// Serial reflected CRC over line-order bits, with residue compare.
module hdlc_rx_crc #(
   parameter int           W       = 16,
   parameter logic [W-1:0] POLY    = '0,
   parameter logic [W-1:0] RESIDUE = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic en,
   input  logic b,
   output logic match
);
   if (W < 8) begin : g_bad_w
      $error("hdlc_rx_crc: W must be at least 8");
   end

   logic [W-1:0] crc;
   logic [W-1:0] crc_nxt;

   always_comb begin
      crc_nxt = crc >> 1;
      if (crc[0] ^ b) crc_nxt = crc_nxt ^ POLY;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || init) crc <= '1;
      else if (en)        crc <= crc_nxt;
   end

   assign match = (crc == RESIDUE);

   AST_CRC_INIT: assert property (@(posedge clk) disable iff (!rst_n) init |=> crc == '1); // R4

endmodule

// File: rtl/hdlc_rx_octets.sv
// Octet assembly, check-byte holdback and frame marker generation.
module hdlc_rx_octets
   import hdlc_rx_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int MAX_FCS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_transparent,
   input  logic              cfg_msb_first,
   input  logic              cfg_len_chk,
   input  logic [1:0]        cfg_crc_sel,
   input  logic              bit_v,
   input  logic              bit_b,
   input  logic              flag_p,
   input  logic              abort_p,
   input  logic              crc_bad,
   output logic              o_valid,
   output logic [BYTE_W-1:0] o_data,
   output logic              o_sop,
   output logic              o_eop,
   output logic              o_abort,
   output logic              o_crc_err,
   output logic              o_len_err
);
   localparam int HD = MAX_FCS + 1;
   localparam int HW = $clog2(HD + 1);
   localparam int IW = (HD > 1) ? $clog2(HD) : 1;
   localparam int BW = $clog2(BYTE_W);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("hdlc_rx_octets: BYTE_W must be at least 2");
   end
   if (MAX_FCS < 0) begin : g_bad_fcs
      $error("hdlc_rx_octets: MAX_FCS must not be negative");
   end

   logic [BYTE_W-1:0] sh, sh_nxt;
   logic [BW-1:0]     bcnt;
   logic              byte_done;
   logic [BYTE_W-1:0] hold [HD];
   logic [HW-1:0]     hcnt, depth;
   logic [IW-1:0]     old_idx;
   logic [BYTE_W-1:0] oldest;
   logic              started;

   always_comb begin
      sh_nxt    = cfg_msb_first ? {sh[BYTE_W-2:0], bit_b} : {bit_b, sh[BYTE_W-1:1]};
      byte_done = (bcnt == BW'(BYTE_W - 1));
      depth     = HW'(fcs_bytes(cfg_crc_sel) + 1);
      old_idx   = IW'(depth - 1'b1);
      oldest    = hold[old_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh        <= '0;
         bcnt      <= '0;
         hcnt      <= '0;
         started   <= 1'b0;
         o_valid   <= 1'b0;
         o_data    <= '0;
         o_sop     <= 1'b0;
         o_eop     <= 1'b0;
         o_abort   <= 1'b0;
         o_crc_err <= 1'b0;
         o_len_err <= 1'b0;
         for (int i = 0; i < HD; i++) hold[i] <= '0;
      end else begin
         o_valid   <= 1'b0;
         o_sop     <= 1'b0;
         o_eop     <= 1'b0;
         o_abort   <= 1'b0;
         o_crc_err <= 1'b0;
         o_len_err <= 1'b0;
         if (cfg_transparent) begin
            if (bit_v) begin
               sh   <= sh_nxt;
               bcnt <= byte_done ? '0 : bcnt + 1'b1;
               if (byte_done) begin
                  o_valid <= 1'b1;
                  o_data  <= sh_nxt;
               end
            end
         end else if (bit_v) begin
            sh   <= sh_nxt;
            bcnt <= byte_done ? '0 : bcnt + 1'b1;
            if (byte_done) begin
               for (int i = HD - 1; i > 0; i--) hold[i] <= hold[i-1];
               hold[0] <= sh_nxt;
               if (hcnt == depth) begin
                  o_valid <= 1'b1;
                  o_data  <= oldest;
                  o_sop   <= !started;
                  started <= 1'b1;
               end else begin
                  hcnt <= hcnt + 1'b1;
               end
            end
         end else if (flag_p || abort_p) begin
            if (hcnt == depth) begin
               o_valid   <= 1'b1;
               o_data    <= oldest;
               o_sop     <= !started;
               o_eop     <= 1'b1;
               o_abort   <= abort_p;
               o_crc_err <= flag_p && crc_bad;
               o_len_err <= flag_p && cfg_len_chk && (bcnt != '0);
            end
            hcnt    <= '0;
            started <= 1'b0;
            bcnt    <= '0;
         end
      end
   end

   AST_EOP_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) o_eop |-> o_valid); // R1
   AST_STATUS_AT_EOP: assert property (@(posedge clk) disable iff (!rst_n) (o_abort || o_crc_err || o_len_err) |-> o_eop); // R4
   AST_ABORT_NO_CHECKS: assert property (@(posedge clk) disable iff (!rst_n) o_abort |-> !(o_crc_err || o_len_err)); // R3
   AST_TRANSPARENT_NO_MARKS: assert property (@(posedge clk) disable iff (!rst_n) (o_valid && $past(cfg_transparent)) |-> !(o_sop || o_eop)); // R6
   AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n) hcnt <= depth); // R4
   AST_LEN_GATED: assert property (@(posedge clk) disable iff (!rst_n) o_len_err |-> $past(cfg_len_chk)); // R5

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int BYTE_W  = 8,
   parameter int RUN_LEN = 6,
   parameter int MAX_FCS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              bit_in,
   input  logic              cfg_transparent,
   input  logic [1:0]        cfg_crc_sel,
   input  logic              cfg_len_chk,
   input  logic              cfg_msb_first,
   input  logic              cfg_invert,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic              out_abort,
   output logic              out_crc_err,
   output logic              out_len_err
);
   if (MAX_FCS < 2) begin : g_bad_fcs
      $error("hdlc_rx_deframer: MAX_FCS must be at least 2");
   end

   logic in_v_q, in_b_q;
   logic zf_v, zf_b, zf_flag, zf_abort;
   logic ok16, ok32, crc_bad, crc_en, crc_init;
   logic asm_v, asm_b;
   logic [1:0] eff_sel;

   // line inversion ahead of everything else
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_v_q <= 1'b0;
         in_b_q <= 1'b0;
      end else begin
         in_v_q <= bit_en;
         in_b_q <= bit_in ^ cfg_invert;
      end
   end

   hdlc_rx_flagger #(.RUN_LEN(RUN_LEN)) u_flagger (
      .clk(clk), .rst_n(rst_n), .in_v(in_v_q), .in_b(in_b_q),
      .dat_v(zf_v), .dat_b(zf_b), .flag_p(zf_flag), .abort_p(zf_abort)
   );

   assign crc_en   = zf_v && !cfg_transparent;
   assign crc_init = zf_flag || zf_abort;

   hdlc_rx_crc #(.W(16), .POLY(CRC16_POLY), .RESIDUE(CRC16_RESIDUE)) u_crc16 (
      .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en), .b(zf_b), .match(ok16)
   );

   if (MAX_FCS >= 4) begin : g_crc32
      hdlc_rx_crc #(.W(32), .POLY(CRC32_POLY), .RESIDUE(CRC32_RESIDUE)) u_crc32 (
         .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en), .b(zf_b), .match(ok32)
      );
      assign eff_sel = cfg_crc_sel;
   end else begin : g_no_crc32
      assign ok32    = 1'b1;
      assign eff_sel = (cfg_crc_sel == FCS_32) ? FCS_OFF : cfg_crc_sel;
   end

   always_comb begin
      case (fcs_sel_e'(eff_sel))
         FCS_16:  crc_bad = !ok16;
         FCS_32:  crc_bad = !ok32;
         default: crc_bad = 1'b0;
      endcase
   end

   assign asm_v = cfg_transparent ? in_v_q : zf_v;
   assign asm_b = cfg_transparent ? in_b_q : zf_b;

   hdlc_rx_octets #(.BYTE_W(BYTE_W), .MAX_FCS(MAX_FCS)) u_octets (
      .clk(clk), .rst_n(rst_n),
      .cfg_transparent(cfg_transparent), .cfg_msb_first(cfg_msb_first),
      .cfg_len_chk(cfg_len_chk), .cfg_crc_sel(eff_sel),
      .bit_v(asm_v), .bit_b(asm_b), .flag_p(zf_flag), .abort_p(zf_abort),
      .crc_bad(crc_bad),
      .o_valid(out_valid), .o_data(out_data), .o_sop(out_sop), .o_eop(out_eop),
      .o_abort(out_abort), .o_crc_err(out_crc_err), .o_len_err(out_len_err)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !out_valid); // R10

endmodule

// File: tb/hdlc_rx_deframer_test.sv
module hdlc_rx_deframer_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0;
   logic bit_in = 1'b0;
   logic cfg_transparent = 1'b0;
   logic [1:0] cfg_crc_sel = 2'b00;
   logic cfg_len_chk = 1'b0;
   logic cfg_msb_first = 1'b0;
   logic cfg_invert = 1'b0;
   logic out_valid, out_sop, out_eop, out_abort, out_crc_err, out_len_err;
   logic [7:0] out_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   hdlc_rx_deframer uut (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .cfg_transparent(cfg_transparent), .cfg_crc_sel(cfg_crc_sel),
      .cfg_len_chk(cfg_len_chk), .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
      .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
      .out_abort(out_abort), .out_crc_err(out_crc_err), .out_len_err(out_len_err)
   );

   typedef struct packed {
      logic [7:0] d;
      logic sop, eop, abt, crc, len;
   } exp_t;

   exp_t        expq[$];
   logic [7:0]  pay[$];
   int          n_run = 0;
   int          n_fail = 0;
   int          ones_tx = 0;
   logic [15:0] c16;
   logic [31:0] c32;
   string       cur_req = "R10";

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_run++;
         if (expq.size() == 0) begin
            n_fail++;
            $display("FAIL %s: unexpected byte %02h sop%0b eop%0b abt%0b crc%0b len%0b, expected none",
                     cur_req, out_data, out_sop, out_eop, out_abort, out_crc_err, out_len_err);
         end else begin
            exp_t e;
            e = expq.pop_front();
            if ({out_data, out_sop, out_eop, out_abort, out_crc_err, out_len_err} !=
                {e.d, e.sop, e.eop, e.abt, e.crc, e.len}) begin
               n_fail++;
               $display("FAIL %s: got %02h sop%0b eop%0b abt%0b crc%0b len%0b, expected %02h sop%0b eop%0b abt%0b crc%0b len%0b",
                        cur_req, out_data, out_sop, out_eop, out_abort, out_crc_err, out_len_err,
                        e.d, e.sop, e.eop, e.abt, e.crc, e.len);
            end
         end
      end
   end

   task automatic push(input logic [7:0] d, input logic s, input logic e, input logic a,
                       input logic c, input logic l);
      exp_t x;
      x.d = d; x.sop = s; x.eop = e; x.abt = a; x.crc = c; x.len = l;
      expq.push_back(x);
   endtask

   task automatic drive_bit(input logic b);
      @(negedge clk);
      bit_en = 1'b1;
      bit_in = b ^ cfg_invert;
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   task automatic tx_stuff(input logic b);
      drive_bit(b);
      if (b) begin
         ones_tx++;
         if (ones_tx == 5) begin
            drive_bit(1'b0);
            ones_tx = 0;
         end
      end else begin
         ones_tx = 0;
      end
   endtask

   task automatic tx_flag();
      drive_bit(1'b0);
      for (int i = 0; i < 6; i++) drive_bit(1'b1);
      drive_bit(1'b0);
      ones_tx = 0;
   endtask

   task automatic crc_upd(input logic b);
      c16 = (c16[0] ^ b) ? ((c16 >> 1) ^ 16'h8408) : (c16 >> 1);
      c32 = (c32[0] ^ b) ? ((c32 >> 1) ^ 32'hEDB88320) : (c32 >> 1);
   endtask

   function automatic logic pick(input logic [7:0] v, input int i);
      return cfg_msb_first ? v[7-i] : v[i];
   endfunction

   task automatic tx_raw_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) drive_bit(pick(v, i));
   endtask

   // full frame: opening flag, payload (one byte optionally corrupted after the
   // check is computed), extra bits, check bytes, closing flag
   task automatic send_frame(input int bad_idx, input int extra);
      int n;
      int fl;
      logic [15:0] f16;
      logic [31:0] f32;
      n = pay.size();
      fl = (cfg_crc_sel == 2'b01) ? 2 : (cfg_crc_sel == 2'b10) ? 4 : 0;
      c16 = '1;
      c32 = '1;
      tx_flag();
      for (int k = 0; k < n; k++) begin
         logic [7:0] sent;
         sent = (k == bad_idx) ? (pay[k] ^ 8'h01) : pay[k];
         for (int i = 0; i < 8; i++) begin
            crc_upd(pick(pay[k], i));
            tx_stuff(pick(sent, i));
         end
         push(sent, k == 0, k == n - 1, 1'b0,
              (k == n - 1) && (fl != 0) && (bad_idx >= 0),
              (k == n - 1) && cfg_len_chk && ((extra % 8) != 0));
      end
      for (int i = 0; i < extra; i++) tx_stuff(i[0]);
      f16 = ~c16;
      f32 = ~c32;
      if (fl == 2) for (int i = 0; i < 16; i++) tx_stuff(f16[i]);
      if (fl == 4) for (int i = 0; i < 32; i++) tx_stuff(f32[i]);
      tx_flag();
   endtask

   task automatic check_empty();
      repeat (12) @(negedge clk);
      n_run++;
      if (expq.size() != 0) begin
         n_fail++;
         $display("FAIL %s: %0d expected bytes missing, expected 0", cur_req, expq.size());
         expq.delete();
      end
   endtask

   task automatic do_reset(input logic tr, input logic [1:0] sel, input logic lc,
                           input logic msb, input logic inv);
      @(negedge clk);
      rst_n = 1'b0;
      bit_en = 1'b0;
      cfg_transparent = tr; cfg_crc_sel = sel; cfg_len_chk = lc;
      cfg_msb_first = msb; cfg_invert = inv;
      repeat (3) @(negedge clk);
      n_run++;
      if ({out_valid, out_sop, out_eop, out_abort, out_crc_err, out_len_err, out_data} != '0) begin
         n_fail++;
         $display("FAIL R10: outputs in reset %0b%0b%0b%0b%0b%0b %02h, expected all 0",
                  out_valid, out_sop, out_eop, out_abort, out_crc_err, out_len_err, out_data);
      end
      rst_n = 1'b1;
      ones_tx = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R10: reset and hunting before the first flag
      do_reset(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      cur_req = "R10";
      tx_raw_byte(8'h12);
      tx_raw_byte(8'h34);
      check_empty();

      // R1: plain framing, crc none
      cur_req = "R1";
      pay = '{8'h11, 8'h22, 8'h33};
      send_frame(-1, 0);
      pay = '{8'hA7};
      send_frame(-1, 0);
      check_empty();

      // R2: zero removal on dense ones
      cur_req = "R2";
      pay = '{8'hFF, 8'h7E, 8'h3F, 8'hFC, 8'hF8, 8'hFF};
      send_frame(-1, 0);
      check_empty();

      // R9: repeated flags, shared-zero flag, idle ones between frames
      cur_req = "R9";
      tx_flag(); tx_flag(); tx_flag();
      for (int i = 0; i < 6; i++) drive_bit(1'b1);
      drive_bit(1'b0);
      for (int i = 0; i < 16; i++) drive_bit(1'b1);
      check_empty();
      pay = '{8'hA5};
      send_frame(-1, 0);
      check_empty();

      // R5: octet length check
      cur_req = "R5";
      cfg_len_chk = 1'b1;
      pay = '{8'hC3, 8'h3C};
      send_frame(-1, 3);
      pay = '{8'h5D, 8'h6E};
      send_frame(-1, 0);
      cfg_len_chk = 1'b0;
      pay = '{8'h0F, 8'hF0};
      send_frame(-1, 5);
      check_empty();

      // R3: abort ends frame, last partial byte lost, then hunt until flag
      cur_req = "R3";
      c16 = '1; c32 = '1;
      tx_flag();
      pay = '{8'h5A, 8'h96, 8'h00};
      foreach (pay[k]) for (int i = 0; i < 8; i++) tx_stuff(pick(pay[k], i));
      push(8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      push(8'h96, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 7; i++) drive_bit(1'b1);
      tx_raw_byte(8'h0F);
      tx_raw_byte(8'h42);
      check_empty();
      pay = '{8'h77, 8'h88};
      send_frame(-1, 0);
      check_empty();

      // R4: 16-bit check, good, corrupted, and check-only (runt) frame
      do_reset(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
      cur_req = "R4";
      pay = '{8'h01, 8'h02, 8'h03};
      send_frame(-1, 0);
      pay = '{8'h10, 8'hFF, 8'h7E, 8'h20};
      send_frame(1, 0);
      check_empty();
      cur_req = "R9";
      pay.delete();
      send_frame(-1, 0);
      check_empty();

      // R4: 32-bit check
      do_reset(1'b0, 2'b10, 1'b0, 1'b0, 1'b0);
      cur_req = "R4";
      pay = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h01};
      send_frame(-1, 0);
      pay = '{8'h3F, 8'hFC, 8'h55};
      send_frame(2, 0);
      check_empty();

      // R4: select 11 means no check, nothing held back
      do_reset(1'b0, 2'b11, 1'b0, 1'b0, 1'b0);
      pay = '{8'h99, 8'h66};
      send_frame(-1, 0);
      check_empty();

      // R7: msb-first order with 16-bit check
      do_reset(1'b0, 2'b01, 1'b0, 1'b1, 1'b0);
      cur_req = "R7";
      pay = '{8'h81, 8'h42, 8'hC0, 8'h07};
      send_frame(-1, 0);
      check_empty();

      // R8: inverted line with 32-bit check
      do_reset(1'b0, 2'b10, 1'b0, 1'b0, 1'b1);
      cur_req = "R8";
      pay = '{8'h7E, 8'hFF, 8'h00, 8'h1B};
      send_frame(-1, 0);
      check_empty();

      // R6: transparent mode passes flags and ones runs as bytes
      do_reset(1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
      cur_req = "R6";
      pay = '{8'h7E, 8'hFF, 8'h00, 8'h3E, 8'hFF};
      foreach (pay[k]) begin
         push(pay[k], 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
         tx_raw_byte(pay[k]);
      end
      check_empty();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule